// File: doc/BRIEF.md
# Sector Decode Interrupt Controller

This block raises and manages the interrupt of a sector-based ECC decode engine inside a NAND controller. The decoder datapath signals each finished sector with a one-cycle pulse carrying the sector index. Software uses a small register bus to start a page (sector count and interrupt mode), enable the interrupt, read a read-to-clear pending status and read a cumulative bitmap of finished sectors. The block drives a single level-sensitive interrupt line.

The block has two interrupt modes. In per-sector mode every finished sector sets the pending status, so a page with several sectors yields several interrupts. In per-page mode a page-tracking state machine counts the pulses and sets the pending status once, on the pulse that finishes the page. The state machine has three states: `PG_IDLE` (no page started since reset), `PG_ACTIVE` (counting sectors) and `PG_COMPLETE` (page finished). It has four transitions. START goes from `PG_IDLE` or `PG_COMPLETE` to `PG_ACTIVE` on a valid page-start write. RESTART stays in `PG_ACTIVE` on a valid page-start write. COUNT stays in `PG_ACTIVE` on a pulse that does not finish the page. FINISH goes from `PG_ACTIVE` to `PG_COMPLETE` on the pulse that brings the count to the page total.

The status clears on a read only while the interrupt is enabled. A sector that finishes after the status has been cleared raises the line again, even when the bitmap already shows every sector done. A pulse that coincides with a status read is never lost.

Top module: `secdec_irq_ctrl`

## Requirements
- R1: In per-sector mode (page register bit 4 = 0, the reset mode), every sector pulse sets the pending status, and with the enable set `irq` goes high two clock edges after the pulse is sampled. Several pulses in one page produce several interrupts when the status is cleared between them.
- R2: A read of offset 0x4 returns the pending status in bit 0 (other bits 0). When the enable (offset 0x0 bit 0) is 1, the same read clears the status, and `irq` falls two edges after the read is sampled.
- R3: When the enable bit is 0, a read of offset 0x4 returns the status and leaves it set.
- R4: Offset 0x8 returns a bitmap with bit i set once a pulse with index i has been sampled. The bitmap is changed only by pulses and page-start writes, and reading it does not clear the pending status.
- R5: A pulse sampled after the status has been cleared sets it again and re-raises `irq`, even when the bitmap already shows every sector of the page done.
- R6: In per-page mode (page register bit 4 = 1), pending is set only by the pulse that brings the number of pulses since the page start up to the page count. Further pulses before the next page start do not set it. Pulses before any page start do not set it.
- R7: A pulse sampled in the same cycle as a status read that would clear the status wins, and the status stays set.
- R8: `irq` is the registered AND of the pending status and the enable bit. A write of 0 to offset 0x0 forces `irq` low two edges after the write is sampled, and writing 1 back brings a still-pending status out again.
- R9: A write to offset 0xC with bits 3:0 in the range 1 to 8 sets the sector count and, through bit 4, the mode. It clears the bitmap and the pending status and starts the page. A pulse in the same cycle is dropped. A write with a count of 0 or above 8 is ignored entirely.
- R10: A read returns its data on `bus_rdata` one cycle after the request is sampled, and `bus_rdata` holds until the next read. Offset 0x0 returns the enable in bit 0, and offset 0xC returns the count in bits 3:0 and the mode in bit 4. Unmapped offsets return 0. After reset the enable is 0, the status and bitmap are 0, the count is 8 and the mode is per-sector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| sec_done | input | 1 | One-cycle pulse: a sector finished decoding |
| sec_idx | input | 3 | Index of the finished sector |
| irq | output | 1 | Level interrupt to the host |

## Verification
The hardest situations to reach are the races. One is a sector pulse in the very cycle of a clearing status read. The other is a late pulse that arrives after the clearing read, when the bitmap already shows the page full. The bench produces both by driving the bus request and the pulse together from one task, in the same cycle or in adjacent cycles. A behavioural model is updated on every edge and compares `irq` and `bus_rdata` on every cycle. The per-page count and the read with the enable off are approached the same way: the stimulus runs full pages and then reads the status before and after toggling the enable.

// File: rtl/secdec_irq_pkg.sv
package secdec_irq_pkg;

    typedef enum logic [1:0] {
        PG_IDLE     = 2'd0,
        PG_ACTIVE   = 2'd1,
        PG_COMPLETE = 2'd2
    } page_state_e;

    localparam logic [3:0] OFS_ENABLE  = 4'h0;
    localparam logic [3:0] OFS_STATUS  = 4'h4;
    localparam logic [3:0] OFS_DONEMAP = 4'h8;
    localparam logic [3:0] OFS_PAGE    = 4'hC;

endpackage

// File: rtl/secdec_regif.sv
module secdec_regif
    import secdec_irq_pkg::*;
#(
    parameter int MAX_SECT = 8,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                pend,
    input  logic [MAX_SECT-1:0] done_map,
    input  logic [CNT_W-1:0]    page_total,
    input  logic                page_mode,
    output logic                irq_en,
    output logic                rd_status,
    output logic                page_wr,
    output logic [CNT_W-1:0]    new_total,
    output logic                new_mode,
    output logic [DATA_W-1:0]   bus_rdata
);

    logic              rd_req;
    logic              wr_req;
    logic              hit_en;
    logic              hit_stat;
    logic              hit_map;
    logic              hit_page;
    logic              cnt_ok;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign rd_req   = bus_sel && !bus_wr;
    assign wr_req   = bus_sel && bus_wr;
    assign hit_en   = (bus_addr == ADDR_W'(OFS_ENABLE));
    assign hit_stat = (bus_addr == ADDR_W'(OFS_STATUS));
    assign hit_map  = (bus_addr == ADDR_W'(OFS_DONEMAP));
    assign hit_page = (bus_addr == ADDR_W'(OFS_PAGE));

    assign new_total = bus_wdata[CNT_W-1:0];
    assign new_mode  = bus_wdata[CNT_W];
    assign cnt_ok    = (new_total != '0) && (new_total <= CNT_W'(MAX_SECT));
    assign page_wr   = wr_req && hit_page && cnt_ok;
    assign rd_status = rd_req && hit_stat;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W+1];

    always_comb begin
        rd_mux = '0;
        if (hit_en) begin
            rd_mux[0] = irq_en;
        end else if (hit_stat) begin
            rd_mux[0] = pend;
        end else if (hit_map) begin
            rd_mux[MAX_SECT-1:0] = done_map;
        end else if (hit_page) begin
            rd_mux[CNT_W-1:0] = page_total;
            rd_mux[CNT_W]     = page_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en    <= 1'b0;
            bus_rdata <= '0;
        end else begin
            if (wr_req && hit_en) begin
                irq_en <= bus_wdata[0];
            end
            if (rd_req) begin
                bus_rdata <= rd_mux;
            end
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata)); // R10

endmodule

// File: rtl/secdec_page_fsm.sv
module secdec_page_fsm
    import secdec_irq_pkg::*;
#(
    parameter int MAX_SECT = 8,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                page_wr,
    input  logic [CNT_W-1:0]    new_total,
    input  logic                new_mode,
    input  logic                sec_done,
    input  logic [IDX_W-1:0]    sec_idx,
    output logic [MAX_SECT-1:0] done_map,
    output logic [CNT_W-1:0]    page_total,
    output logic                page_mode,
    output logic                sec_evt
);

    page_state_e         state_q;
    page_state_e         state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    cnt_d;
    logic [MAX_SECT-1:0] map_d;
    logic [CNT_W-1:0]    total_d;
    logic                mode_d;
    logic                hit;
    logic                is_last;
    logic                page_done;

    assign hit     = sec_done && !page_wr;
    assign is_last = ((cnt_q + 1'b1) == page_total);

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= PG_IDLE;
            cnt_q      <= '0;
            done_map   <= '0;
            page_total <= CNT_W'(MAX_SECT);
            page_mode  <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            done_map   <= map_d;
            page_total <= total_d;
            page_mode  <= mode_d;
        end
    end

    // next-state and output process
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        page_done = 1'b0;
        unique case (state_q)
            PG_IDLE: begin
                if (page_wr) begin
                    state_d = PG_ACTIVE;   // START
                    cnt_d   = '0;
                end
            end
            PG_ACTIVE: begin
                if (page_wr) begin
                    cnt_d = '0;            // RESTART
                end else if (hit) begin
                    cnt_d = cnt_q + 1'b1;  // COUNT
                    if (is_last) begin
                        state_d   = PG_COMPLETE;  // FINISH
                        page_done = 1'b1;
                    end
                end
            end
            PG_COMPLETE: begin
                if (page_wr) begin
                    state_d = PG_ACTIVE;   // START
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = PG_IDLE;
                cnt_d   = '0;
            end
        endcase

        map_d = done_map;
        if (page_wr) begin
            map_d = '0;
        end else if (hit) begin
            map_d[sec_idx] = 1'b1;
        end

        total_d = page_wr ? new_total : page_total;
        mode_d  = page_wr ? new_mode  : page_mode;
        sec_evt = hit && (!page_mode || page_done);
    end

    AST_MAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_wr && !sec_done) |=> $stable(done_map)); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PG_IDLE) |-> (cnt_q <= page_total)); // R6

endmodule

// File: rtl/secdec_pend.sv
module secdec_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_evt,
    input  logic page_wr,
    input  logic rd_status,
    input  logic irq_en,
    output logic pend,
    output logic irq
);

    logic clr;
    logic pend_d;

    assign clr = rd_status && irq_en;

    always_comb begin
        if (page_wr) begin
            pend_d = 1'b0;
        end else if (sec_evt) begin
            pend_d = 1'b1;
        end else if (clr) begin
            pend_d = 1'b0;
        end else begin
            pend_d = pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
            irq  <= 1'b0;
        end else begin
            pend <= pend_d;
            irq  <= pend && irq_en;
        end
    end

    AST_CLR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> ($past(page_wr) || ($past(rd_status) && $past(irq_en)))); // R3

endmodule

// File: rtl/secdec_irq_ctrl.sv
module secdec_irq_ctrl
    import secdec_irq_pkg::*;
#(
    parameter int MAX_SECT = 8,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic                         sec_done,
    input  logic [$clog2(MAX_SECT)-1:0]  sec_idx,
    output logic                         irq
);

    localparam int IDX_W = $clog2(MAX_SECT);
    localparam int CNT_W = $clog2(MAX_SECT + 1);

    logic                irq_en;
    logic                rd_status;
    logic                page_wr;
    logic [CNT_W-1:0]    new_total;
    logic                new_mode;
    logic                pend;
    logic [MAX_SECT-1:0] done_map;
    logic [CNT_W-1:0]    page_total;
    logic                page_mode;
    logic                sec_evt;

    secdec_regif #(
        .MAX_SECT(MAX_SECT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .pend(pend), .done_map(done_map), .page_total(page_total), .page_mode(page_mode),
        .irq_en(irq_en), .rd_status(rd_status), .page_wr(page_wr),
        .new_total(new_total), .new_mode(new_mode), .bus_rdata(bus_rdata)
    );

    secdec_page_fsm #(
        .MAX_SECT(MAX_SECT), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .page_wr(page_wr), .new_total(new_total), .new_mode(new_mode),
        .sec_done(sec_done), .sec_idx(sec_idx),
        .done_map(done_map), .page_total(page_total), .page_mode(page_mode),
        .sec_evt(sec_evt)
    );

    secdec_pend u_pend (
        .clk(clk), .rst_n(rst_n),
        .sec_evt(sec_evt), .page_wr(page_wr), .rd_status(rd_status), .irq_en(irq_en),
        .pend(pend), .irq(irq)
    );

    AST_MASK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_ENABLE) && !bus_wdata[0])
        |-> ##2 !irq); // R8

    AST_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_done && !page_mode && irq_en && bus_sel && !bus_wr
         && bus_addr == ADDR_W'(OFS_STATUS)) |-> ##2 irq); // R7

endmodule

// File: tb/secdec_irq_ctrl_test.sv
module secdec_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_done = 1'b0;
    logic [2:0]  sec_idx = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    string phase = "R10";

    always #5 clk = ~clk;

    secdec_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_done(sec_done), .sec_idx(sec_idx), .irq(irq)
    );

    // behavioural reference model
    int   m_en, m_pend, m_map, m_total, m_mode, m_cnt, m_active, m_irq, m_rdata;

    always @(posedge clk) begin
        int  rd, wq, pagewr, evt, a, c;
        if (!rst_n) begin
            m_en = 0; m_pend = 0; m_map = 0; m_total = 8; m_mode = 0;
            m_cnt = 0; m_active = 0; m_irq = 0; m_rdata = 0;
        end else begin
            rd = bus_sel && !bus_wr;
            wq = bus_sel && bus_wr;
            a  = bus_addr;
            c  = bus_wdata[3:0];
            pagewr = wq && a == 12 && c >= 1 && c <= 8;
            if (rd) begin
                case (a)
                    0:  m_rdata = m_en;
                    4:  m_rdata = m_pend;
                    8:  m_rdata = m_map;
                    12: m_rdata = m_mode * 16 + m_total;
                    default: m_rdata = 0;
                endcase
            end
            evt = 0;
            if (sec_done && !pagewr) begin
                m_map = m_map | (1 << sec_idx);
                if (m_mode == 0) evt = 1;
                else if (m_active != 0) begin
                    m_cnt = m_cnt + 1;
                    if (m_cnt == m_total) begin evt = 1; m_active = 0; end
                end
            end
            m_irq = (m_pend != 0 && m_en != 0) ? 1 : 0;
            if (pagewr) m_pend = 0;
            else if (evt != 0) m_pend = 1;
            else if (rd && a == 4 && m_en != 0) m_pend = 0;
            if (wq && a == 0) m_en = bus_wdata[0];
            if (pagewr) begin
                m_map = 0; m_total = c; m_mode = bus_wdata[4];
                m_cnt = 0; m_active = 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk({phase, " irq"}, int'(irq), m_irq);
            chk({phase, " rdata"}, int'(bus_rdata), m_rdata);
        end
    end

    task automatic drive(input logic s, input logic w, input logic [3:0] a,
                         input logic [31:0] d, input logic p, input logic [2:0] i);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        sec_done = p; sec_idx = i;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; sec_done = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        drive(1'b1, 1'b1, a, d, 1'b0, 3'd0);
    endtask
    task automatic rd(input logic [3:0] a);
        drive(1'b1, 1'b0, a, 32'd0, 1'b0, 3'd0);
    endtask
    task automatic pulse(input logic [2:0] i);
        drive(1'b0, 1'b0, 4'h0, 32'd0, 1'b1, i);
    endtask
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        phase = "R10";
        chk("R10 irq after reset", int'(irq), 0);
        rd(4'h4); chk("R10 status after reset", int'(bus_rdata), 0);
        rd(4'hC); chk("R10 page reg after reset", int'(bus_rdata), 8);
        wr(4'h0, 32'h1);
        rd(4'h0); chk("R10 enable readback", int'(bus_rdata), 1);
        rd(4'h2); chk("R10 unmapped read", int'(bus_rdata), 0);
        idle(2); chk("R10 rdata holds", int'(bus_rdata), 0);

        // R9 page start, per-sector
        phase = "R9";
        wr(4'hC, 32'h04);
        rd(4'hC); chk("R9 page count/mode", int'(bus_rdata), 4);

        // R1 per-sector interrupts
        phase = "R1";
        for (int s = 0; s < 4; s++) begin
            pulse(3'(s));
            idle(1);
            chk("R1 irq per sector", int'(irq), 1);
            // R4 bitmap read does not clear
            phase = "R4";
            rd(4'h8); chk("R4 bitmap", int'(bus_rdata), (2 << s) - 1);
            idle(1); chk("R4 irq kept after bitmap read", int'(irq), 1);
            // R2 status read clears
            phase = "R2";
            rd(4'h4); chk("R2 status read value", int'(bus_rdata), 1);
            idle(1); chk("R2 irq dropped", int'(irq), 0);
            phase = "R1";
        end

        // R5 late sector after clear with full bitmap
        phase = "R5";
        pulse(3'd3);
        idle(1); chk("R5 irq re-raised", int'(irq), 1);
        rd(4'h8); chk("R5 bitmap full", int'(bus_rdata), 32'hF);
        rd(4'h4); idle(1);

        // R7 pulse in same cycle as clearing read
        phase = "R7";
        drive(1'b1, 1'b0, 4'h4, 32'd0, 1'b1, 3'd1);
        idle(1); chk("R7 irq kept", int'(irq), 1);
        rd(4'h4); chk("R7 status still set", int'(bus_rdata), 1);
        idle(1);

        // R3 enable off: read does not clear
        phase = "R3";
        wr(4'h0, 32'h0);
        pulse(3'd2);
        rd(4'h4); chk("R3 status read", int'(bus_rdata), 1);
        rd(4'h4); chk("R3 status still set", int'(bus_rdata), 1);
        chk("R3 irq masked", int'(irq), 0);

        // R8 re-enable brings irq back
        phase = "R8";
        wr(4'h0, 32'h1);
        idle(1); chk("R8 irq after re-enable", int'(irq), 1);
        wr(4'h0, 32'h0);
        idle(1); chk("R8 irq masked next", int'(irq), 0);
        wr(4'h0, 32'h1);
        rd(4'h4); idle(1);

        // R6 per-page mode
        phase = "R6";
        wr(4'hC, 32'h13);
        for (int s = 0; s < 2; s++) begin
            pulse(3'(s)); idle(1);
            chk("R6 no irq before last", int'(irq), 0);
        end
        pulse(3'd2); idle(1);
        chk("R6 irq on last sector", int'(irq), 1);
        rd(4'h4); idle(1);
        pulse(3'd5); idle(2);
        chk("R6 no irq after page done", int'(irq), 0);
        rd(4'h8); chk("R6 bitmap", int'(bus_rdata), 32'h27);

        // R9 invalid counts ignored, same-cycle pulse dropped
        phase = "R9";
        wr(4'hC, 32'h09);
        rd(4'hC); chk("R9 count 9 ignored", int'(bus_rdata), 32'h13);
        wr(4'hC, 32'h00);
        rd(4'hC); chk("R9 count 0 ignored", int'(bus_rdata), 32'h13);
        wr(4'h0, 32'h1);
        pulse(3'd6);
        drive(1'b1, 1'b1, 4'hC, 32'h02, 1'b1, 3'd4);
        rd(4'h8); chk("R9 bitmap cleared, pulse dropped", int'(bus_rdata), 0);
        rd(4'h4); chk("R9 pending cleared", int'(bus_rdata), 0);
        pulse(3'd0); pulse(3'd1); idle(1);
        chk("R9 per-sector after restart", int'(irq), 1);
        rd(4'h4); idle(2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule